// File: doc/BRIEF.md
# Byte and Word Arithmetic Unit with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It takes an operation code, the accumulator, the index byte that is paired with the accumulator for 16-bit work, a two-byte operand and the current status byte. One clock edge later it presents the result and the updated status byte. Byte operations cover add with carry, subtract with borrow, compare, the three bitwise operations, increment and decrement, four shift and rotate forms, nibble exchange, and decimal correction after an add and after a subtract. Word operations treat the index byte and the accumulator as one 16-bit value, with the index byte as the high half. They add, subtract or compare it against the two operand bytes.

Each operation changes only the flags that belong to it. All other status bits leave the block as they came in. The surrounding datapath therefore writes the whole status byte back every cycle without any masking. Register storage, memory access and instruction decode live outside the block.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high, `res_lo_o`, `res_hi_o` and `psw_o` are all zero. Otherwise every output reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R2: Op code 0 (add with carry) gives `res_lo_o` = (A + B + C) mod 256 and sets C to the carry out of bit 7. H is the carry out of bit 3. V is set when A and B have the same sign and the result sign differs. N is result bit 7 and Z is set when the result is zero.
- R3: Op code 1 (subtract with borrow) behaves as op 0 with B replaced by its bitwise inverse. C set afterwards means no borrow occurred.
- R4: Op code 2 (compare) forms A − B with no carry-in. It sets N and Z from the 8-bit difference and sets C when A ≥ B. It leaves `res_lo_o` equal to A and leaves V and H unchanged.
- R5: Op codes 3, 4 and 5 give A AND B, A OR B and A XOR B. Op codes 6 and 7 give A+1 and A−1, wrapping modulo 256. These five update only N and Z.
- R6: Op codes 8 to 11 shift A one place. Op 8 shifts left with 0 in. Op 9 shifts left with the old C in. Op 10 shifts right with 0 in. Op 11 shifts right with the old C in. The bit shifted out becomes C, and N and Z follow the result.
- R7: Op code 12 swaps the high and low nibbles of A and sets N and Z from the swapped value.
- R8: Op code 13 (decimal correct after add) first adds 0x60 and sets C if A > 0x99 or C is set. It then adds 0x06 if the low nibble of A is above 9 or H is set. The result is taken modulo 256, N and Z follow it, and C is otherwise kept.
- R9: Op code 14 (decimal correct after subtract) first subtracts 0x60 and clears C if A > 0x99 or C is clear. It then subtracts 0x06 if the low nibble of A is above 9 or H is clear. The result is taken modulo 256, N and Z follow it, and C is otherwise kept.
- R10: Op codes 15 and 16 add to, or subtract from, W = {Y, A} the operand {B_hi, B_lo}. There is no carry-in; subtract adds the inverse plus one. The low half goes to `res_lo_o` and the high half to `res_hi_o`. C is the carry out of bit 15, which means no borrow for op 16. H is the carry out of bit 11. V is signed 16-bit overflow, N is bit 15, and Z is set only when all 16 bits are zero.
- R11: Op code 17 (word compare) sets N, Z and C from W − {B_hi, B_lo}, with C meaning W ≥ operand. It returns A and Y unchanged and leaves V and H alone.
- R12: The status byte is laid out as N=bit 7, V=bit 6, page select=bit 5, break=bit 4, H=bit 3, interrupt enable=bit 2, Z=bit 1, C=bit 0. Bits 5, 4 and 2 always pass through. Every byte operation returns Y on `res_hi_o`. Op codes 18 to 31 return A, Y and the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator A (low half of W) |
| ext_i | input | 8 | Index byte Y (high half of W) |
| opnd_lo_i | input | 8 | Operand B, low byte of the word operand |
| opnd_hi_i | input | 8 | High byte of the word operand |
| psw_i | input | 8 | Current status byte |
| res_lo_o | output | 8 | Byte result, or low half of the word result |
| res_hi_o | output | 8 | High half of the word result, Y for byte operations |
| psw_o | output | 8 | Updated status byte |

## Verification
Two things can happen in the same cycle and both have to be right: the carry out of bit 3 and the signed overflow can fire together with the carry out of bit 7, and the two decimal correction steps can both apply at once. The bench provokes these by sweeping every accumulator value against a spread of operands, including 0xFF, under both incoming carries. For the decimal corrections it sweeps every accumulator value under all four combinations of incoming C and H. Each vector compares the whole result and status byte against an arithmetic model, so a flag that is lost when another flag also changes shows up directly. The word operations get corner vectors at the bit-11, bit-15 and bit-16 carry boundaries on top of a pseudo-random sweep.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int OPW = 5;

  // status byte bit positions
  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_I = 2;
  localparam int ST_H = 3;
  localparam int ST_B = 4;
  localparam int ST_P = 5;
  localparam int ST_V = 6;
  localparam int ST_N = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADC  = 5'd0,
    OP_SBC  = 5'd1,
    OP_CMP  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_SHL  = 5'd8,
    OP_RLC  = 5'd9,
    OP_SHR  = 5'd10,
    OP_RRC  = 5'd11,
    OP_SWAP = 5'd12,
    OP_DADD = 5'd13,
    OP_DSUB = 5'd14,
    OP_WADD = 5'd15,
    OP_WSUB = 5'd16,
    OP_WCMP = 5'd17
  } op_e;
endpackage

// File: rtl/alu_addsub.sv
// Adder with optional operand inversion; reports carry, mid carry and overflow.
module alu_addsub #(
  parameter int DW   = 8,
  parameter int HBIT = 3
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          inv_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          hc_o,
  output logic          ov_o
);
  logic [DW-1:0] opnd;
  logic [DW:0]   full;
  logic [DW-1:0] mix;

  always_comb begin
    opnd   = inv_i ? ~y_i : y_i;
    full   = {1'b0, x_i} + {1'b0, opnd} + {{DW{1'b0}}, cin_i};
    sum_o  = full[DW-1:0];
    cout_o = full[DW];
    mix    = x_i ^ opnd ^ full[DW-1:0];
    hc_o   = mix[HBIT+1];
    ov_o   = ~(x_i[DW-1] ^ opnd[DW-1]) & (x_i[DW-1] ^ full[DW-1]);
  end
endmodule

// File: rtl/alu_shift.sv
// Single-place shifts, rotates through carry, and nibble swap.
module alu_shift
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  localparam int NB = DW / 2;

  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    case (op_i)
      OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0};  cout_o = a_i[DW-1]; end
      OP_RLC: begin res_o = {a_i[DW-2:0], cin_i}; cout_o = a_i[DW-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]};  cout_o = a_i[0];    end
      OP_RRC: begin res_o = {cin_i, a_i[DW-1:1]}; cout_o = a_i[0];    end
      OP_SWAP: res_o = {a_i[NB-1:0], a_i[DW-1:NB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
// Decimal correction after add (sub_i=0) or after subtract (sub_i=1).
module alu_decadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  input  logic          hin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  localparam int NB = DW / 2;
  localparam logic [DW-1:0] K_LO = DW'(6);
  localparam logic [DW-1:0] K_HI = K_LO << NB;
  localparam logic [DW-1:0] LIM  = (DW'(9) << NB) | DW'(9);

  logic          big;
  logic          fix;
  logic [DW-1:0] step;

  always_comb begin
    if (sub_i) begin
      big  = (a_i > LIM) || !cin_i;
      fix  = (a_i[NB-1:0] > NB'(9)) || !hin_i;
      step = big ? a_i - K_HI : a_i;
      res_o = fix ? step - K_LO : step;
      cout_o = !big;
    end else begin
      big  = (a_i > LIM) || cin_i;
      fix  = (a_i[NB-1:0] > NB'(9)) || hin_i;
      step = big ? a_i + K_HI : a_i;
      res_o = fix ? step + K_LO : step;
      cout_o = big;
    end
  end
endmodule

// File: rtl/byte_alu.sv
// Registered byte/word ALU; one cycle from inputs to result and status.
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  ext_i,
  input  logic [DW-1:0]  opnd_lo_i,
  input  logic [DW-1:0]  opnd_hi_i,
  input  logic [7:0]     psw_i,
  output logic [DW-1:0]  res_lo_o,
  output logic [DW-1:0]  res_hi_o,
  output logic [7:0]     psw_o
);
  localparam int WW = 2 * DW;
  localparam int NB = DW / 2;

  op_e op;
  assign op = op_e'(op_i);

  // byte and word adders differ only in width and mid-carry tap
  logic          b_inv, b_cin, b_co, b_hc, b_ov;
  logic [DW-1:0] b_sum;
  logic          w_inv, w_co, w_hc, w_ov;
  logic [WW-1:0] w_sum;

  assign b_inv = (op == OP_SBC) || (op == OP_CMP);
  assign b_cin = (op == OP_CMP) ? 1'b1 : psw_i[ST_C];
  assign w_inv = (op != OP_WADD);

  alu_addsub #(.DW(DW), .HBIT(NB - 1)) u_badd (
    .x_i(acc_i), .y_i(opnd_lo_i), .cin_i(b_cin), .inv_i(b_inv),
    .sum_o(b_sum), .cout_o(b_co), .hc_o(b_hc), .ov_o(b_ov)
  );

  alu_addsub #(.DW(WW), .HBIT(DW + NB - 1)) u_wadd (
    .x_i({ext_i, acc_i}), .y_i({opnd_hi_i, opnd_lo_i}), .cin_i(w_inv), .inv_i(w_inv),
    .sum_o(w_sum), .cout_o(w_co), .hc_o(w_hc), .ov_o(w_ov)
  );

  logic [DW-1:0] sh_res;
  logic          sh_co;
  alu_shift #(.DW(DW)) u_shift (
    .op_i(op), .a_i(acc_i), .cin_i(psw_i[ST_C]), .res_o(sh_res), .cout_o(sh_co)
  );

  logic [DW-1:0] da_res;
  logic          da_co;
  alu_decadj #(.DW(DW)) u_dec (
    .a_i(acc_i), .cin_i(psw_i[ST_C]), .hin_i(psw_i[ST_H]), .sub_i(op == OP_DSUB),
    .res_o(da_res), .cout_o(da_co)
  );

  logic [DW-1:0] nxt_lo, nxt_hi, lg;
  logic [7:0]    nxt_psw;

  always_comb begin
    nxt_lo  = acc_i;
    nxt_hi  = ext_i;
    nxt_psw = psw_i;
    lg      = acc_i;
    case (op)
      OP_ADC, OP_SBC: begin
        nxt_lo        = b_sum;
        nxt_psw[ST_N] = b_sum[DW-1];
        nxt_psw[ST_Z] = ~|b_sum;
        nxt_psw[ST_V] = b_ov;
        nxt_psw[ST_H] = b_hc;
        nxt_psw[ST_C] = b_co;
      end
      OP_CMP: begin
        nxt_psw[ST_N] = b_sum[DW-1];
        nxt_psw[ST_Z] = ~|b_sum;
        nxt_psw[ST_C] = b_co;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        case (op)
          OP_AND:  lg = acc_i & opnd_lo_i;
          OP_OR:   lg = acc_i | opnd_lo_i;
          OP_XOR:  lg = acc_i ^ opnd_lo_i;
          OP_INC:  lg = acc_i + DW'(1);
          default: lg = acc_i - DW'(1);
        endcase
        nxt_lo        = lg;
        nxt_psw[ST_N] = lg[DW-1];
        nxt_psw[ST_Z] = ~|lg;
      end
      OP_SHL, OP_RLC, OP_SHR, OP_RRC, OP_SWAP: begin
        nxt_lo        = sh_res;
        nxt_psw[ST_N] = sh_res[DW-1];
        nxt_psw[ST_Z] = ~|sh_res;
        nxt_psw[ST_C] = sh_co;
      end
      OP_DADD, OP_DSUB: begin
        nxt_lo        = da_res;
        nxt_psw[ST_N] = da_res[DW-1];
        nxt_psw[ST_Z] = ~|da_res;
        nxt_psw[ST_C] = da_co;
      end
      OP_WADD, OP_WSUB: begin
        nxt_lo        = w_sum[DW-1:0];
        nxt_hi        = w_sum[WW-1:DW];
        nxt_psw[ST_N] = w_sum[WW-1];
        nxt_psw[ST_Z] = ~|w_sum;
        nxt_psw[ST_V] = w_ov;
        nxt_psw[ST_H] = w_hc;
        nxt_psw[ST_C] = w_co;
      end
      OP_WCMP: begin
        nxt_psw[ST_N] = w_sum[WW-1];
        nxt_psw[ST_Z] = ~|w_sum;
        nxt_psw[ST_C] = w_co;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo_o <= '0;
      res_hi_o <= '0;
      psw_o    <= '0;
    end else begin
      res_lo_o <= nxt_lo;
      res_hi_o <= nxt_hi;
      psw_o    <= nxt_psw;
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  ext_i,
  input logic [DW-1:0]  opnd_lo_i,
  input logic [DW-1:0]  opnd_hi_i,
  input logic [7:0]     psw_i,
  input logic [DW-1:0]  res_lo_o,
  input logic [DW-1:0]  res_hi_o,
  input logic [7:0]     psw_o
);
  p_fixed_bits_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (psw_o[ST_P] == $past(psw_i[ST_P])) && (psw_o[ST_B] == $past(psw_i[ST_B]))
                    && (psw_o[ST_I] == $past(psw_i[ST_I])));

  p_undef_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) > OP_WCMP)) |->
      (res_lo_o == $past(acc_i)) && (res_hi_o == $past(ext_i)) && (psw_o == $past(psw_i)));

  p_byte_hi_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) <= OP_DSUB)) |-> (res_hi_o == $past(ext_i)));

  p_logic_nz_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) >= OP_AND) && ($past(op_i) <= OP_DEC)) |->
      (psw_o[ST_Z] == (res_lo_o == '0)) && (psw_o[ST_N] == res_lo_o[DW-1])
      && (psw_o[ST_V] == $past(psw_i[ST_V])) && (psw_o[ST_H] == $past(psw_i[ST_H]))
      && (psw_o[ST_C] == $past(psw_i[ST_C])));

  p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_CMP)) |->
      (res_lo_o == $past(acc_i)) && (psw_o[ST_V] == $past(psw_i[ST_V]))
      && (psw_o[ST_H] == $past(psw_i[ST_H])));

  p_word_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(op_i) == OP_WADD) || ($past(op_i) == OP_WSUB))) |->
      (psw_o[ST_Z] == ({res_hi_o, res_lo_o} == '0)) && (psw_o[ST_N] == res_hi_o[DW-1]));

  p_wcmp_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_WCMP)) |->
      (res_lo_o == $past(acc_i)) && (res_hi_o == $past(ext_i))
      && (psw_o[ST_V] == $past(psw_i[ST_V])) && (psw_o[ST_H] == $past(psw_i[ST_H])));
endmodule

bind byte_alu byte_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .ext_i(ext_i),
  .opnd_lo_i(opnd_lo_i), .opnd_hi_i(opnd_hi_i), .psw_i(psw_i),
  .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .psw_o(psw_o)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, ext_i = '0, opnd_lo_i = '0, opnd_hi_i = '0, psw_i = '0;
  logic [7:0] res_lo_o, res_hi_o, psw_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .ext_i(ext_i),
    .opnd_lo_i(opnd_lo_i), .opnd_hi_i(opnd_hi_i), .psw_i(psw_i),
    .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .psw_o(psw_o)
  );

  function automatic string tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5, 6, 7: return "R5";
      8, 9, 10, 11: return "R6";
      12: return "R7";
      13: return "R8";
      14: return "R9";
      15, 16: return "R10";
      17: return "R11";
      default: return "R12";
    endcase
  endfunction

  // arithmetic reference built from the requirement text; returns {lo, hi, status}
  function automatic logic [23:0] model(int op, int a, int y, int lo, int hi, int st);
    int r, rh, c, h, v, n, z, t, s, x16, o16, rr, ci;
    r = a; rh = y;
    c = st & 1; z = (st >> 1) & 1; h = (st >> 3) & 1; v = (st >> 6) & 1; n = (st >> 7) & 1;
    case (op)
      0, 1: begin
        t = (op == 1) ? (~lo & 255) : lo;
        s = a + t + c;
        h = (((a & 15) + (t & 15) + c) > 15) ? 1 : 0;
        r = s & 255;
        c = (s > 255) ? 1 : 0;
        v = (((a ^ t) & 128) == 0 && ((a ^ r) & 128) != 0) ? 1 : 0;
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      2: begin
        c = (a >= lo) ? 1 : 0;
        t = (a - lo) & 255;
        n = (t >> 7) & 1; z = (t == 0) ? 1 : 0;
      end
      3, 4, 5, 6, 7, 12: begin
        case (op)
          3: r = a & lo;
          4: r = a | lo;
          5: r = a ^ lo;
          6: r = (a + 1) & 255;
          7: r = (a + 255) & 255;
          default: r = ((a & 15) << 4) | (a >> 4);
        endcase
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      8, 9, 10, 11: begin
        ci = (op == 9 || op == 11) ? c : 0;
        if (op < 10) begin r = ((a << 1) & 255) | ci; c = (a >> 7) & 1; end
        else begin r = (a >> 1) | (ci << 7); c = a & 1; end
        n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      13: begin
        t = a;
        if (a > 153 || c == 1) begin t = t + 96; c = 1; end
        if ((a & 15) > 9 || h == 1) t = t + 6;
        r = t & 255; n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      14: begin
        t = a;
        if (a > 153 || c == 0) begin t = t - 96; c = 0; end
        if ((a & 15) > 9 || h == 0) t = t - 6;
        r = t & 255; n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
      end
      15, 16: begin
        x16 = y * 256 + a; o16 = hi * 256 + lo;
        ci = (op == 16) ? 1 : 0;
        t = (op == 16) ? (~o16 & 65535) : o16;
        s = x16 + t + ci;
        rr = s & 65535;
        c = (s > 65535) ? 1 : 0;
        h = (((x16 & 4095) + (t & 4095) + ci) > 4095) ? 1 : 0;
        v = (((x16 ^ t) & 32768) == 0 && ((x16 ^ rr) & 32768) != 0) ? 1 : 0;
        r = rr & 255; rh = rr >> 8;
        n = (rr >> 15) & 1; z = (rr == 0) ? 1 : 0;
      end
      17: begin
        x16 = y * 256 + a; o16 = hi * 256 + lo;
        c = (x16 >= o16) ? 1 : 0;
        rr = (x16 - o16) & 65535;
        n = (rr >> 15) & 1; z = (rr == 0) ? 1 : 0;
      end
      default: ;
    endcase
    s = (st & 8'h34) | (n << 7) | (v << 6) | (h << 3) | (z << 1) | c;
    return {8'(r), 8'(rh), 8'(s)};
  endfunction

  // drive at a falling edge, result registered at the rising edge, sample at next falling edge
  task automatic apply(int op, int a, int y, int lo, int hi, int st);
    logic [23:0] exp_v;
    op_i = 5'(op); acc_i = 8'(a); ext_i = 8'(y); opnd_lo_i = 8'(lo); opnd_hi_i = 8'(hi); psw_i = 8'(st);
    exp_v = model(op, a, y, lo, hi, st);
    @(negedge clk);
    total++;
    if ({res_lo_o, res_hi_o, psw_o} !== exp_v) begin
      bad++;
      $display("FAIL %s op=%0d a=%h y=%h b=%h:%h st=%h got=%h expected=%h",
               tag(op), op, a, y, hi, lo, st, {res_lo_o, res_hi_o, psw_o}, exp_v);
    end
  endtask

  task automatic check_reset();
    total++;
    if ({res_lo_o, res_hi_o, psw_o} !== 24'h0) begin
      bad++;
      $display("FAIL R1 reset got=%h expected=000000", {res_lo_o, res_hi_o, psw_o});
    end
  endtask

  initial begin
    int seed;
    // R1: outputs held at zero during reset even with live inputs
    op_i = 5'd0; acc_i = 8'hFF; ext_i = 8'hFF; opnd_lo_i = 8'h01; psw_i = 8'hFF;
    repeat (3) @(negedge clk);
    check_reset();
    @(negedge clk);
    check_reset();
    rst = 1'b0;

    // binary byte ops: R2 R3 R4 R5 -- every A, spread of B, both carries
    for (int op = 0; op <= 5; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k <= 20; k++)
          for (int c = 0; c < 2; c++) begin
            int b;
            b = (k == 20) ? 255 : k * 13;
            apply(op, a, (a * 3 + k) & 255, b, k, (((a * 7 + k * 3) & 255) & ~1) | c);
          end

    // unary byte ops R5 R6 R7 R8 R9 plus reserved codes R12, all C/H combos
    for (int op = 6; op <= 19; op++)
      if (op <= 14 || op == 18 || op == 19)
        for (int a = 0; a < 256; a++)
          for (int ch = 0; ch < 4; ch++)
            apply((op == 19) ? 31 : op, a, 255 - a, a ^ 8'h5A, 8'h33,
                  (((a * 5) & 8'hF6) | (ch & 1) | ((ch >> 1) << 3)));

    // word ops R10 R11: boundary corners, then pseudo-random sweep
    for (int op = 15; op <= 17; op++) begin
      apply(op, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      apply(op, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h01);
      apply(op, 8'hFF, 8'h7F, 8'h01, 8'h00, 8'hFE);
      apply(op, 8'h00, 8'h80, 8'h01, 8'h00, 8'h00);
      apply(op, 8'hFF, 8'h0F, 8'h01, 8'h00, 8'h00);
      apply(op, 8'h00, 8'h10, 8'h01, 8'h00, 8'hFF);
      apply(op, 8'h34, 8'h12, 8'h34, 8'h12, 8'h00);
      apply(op, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    end
    seed = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      int op;
      seed = seed * 1103515245 + 12345;
      op = 15 + (i % 3);
      apply(op, (seed >> 8) & 255, (seed >> 16) & 255, (seed >> 24) & 255,
            ((seed >> 4) ^ i) & 255, (seed >> 12) & 255);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired got=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule